// File: doc/BRIEF.md
# Complementary PWM Timebase with Dead-Time Offset

This block supplies the counting timebase for three-phase complementary PWM. It has two main up/down counters and one subcounter. On a restart the first main counter is preloaded with a programmable dead-time value and the second is cleared, so the two run a fixed dead-time apart. Each main counter rises to a peak equal to dead-time plus half-period, then falls to zero, and repeats. The subcounter ramps up from zero to the same peak. After that it moves only inside the band between the half-period value and the peak. It turns from falling to rising when it equals the half-period register.

Software reaches the block over a plain 16-bit register bus with address, write strobe, width qualifier, write data and combinational read data. Only full-width writes take effect. A narrow write changes nothing and raises an error pulse. The control word also holds a three-bit phase code that decides which of the six phase outputs are enabled. There are three high-side outputs and three low-side outputs, one of each for phases U, V and W. The bus and all outputs are plain control and status pins. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Counting is defined for a dead-time of at least 1 and a half-period of at least 1, with their sum no larger than 0xFFFF. The peak is the 16-bit sum of the two.

Top module: `cpwm_timebase`

## Requirements
- R1: After reset, the dead-time and half-period registers read 0xFFFF. The control word, all three counters, the error flag and all six phase outputs read 0. All direction flags show counting up.
- R2: A write with `bus_wide` low changes no register. It sets `bus_err` high for exactly the cycle after the write. A full-width write leaves `bus_err` low.
- R3: Writes to the counter addresses (3, 4 and 5) are ignored, so the subcounter and both main counters are read-only from the bus.
- R4: A full-width write to the control word (address 0) with bit 0 set, made while stopped, restarts the block. In the next cycle the first main counter holds the dead-time value, the second main counter and the subcounter hold 0, and every direction is up.
- R5: While running, each main counter steps by one per cycle. A main counter that is counting up and equals the peak turns and steps down. One that is counting down and equals zero turns and steps up. `main_down` shows each counter's current direction: bit 0 for the first counter, bit 1 for the second.
- R6: The subcounter starts upward. When it is counting up and equals the peak, it turns down. When it is counting down and equals the half-period register, it turns up and increments in the following cycle. `sub_up` shows its direction.
- R7: Clearing control bit 0 freezes all counters and directions. Writing bit 0 = 1 while already running causes no restart.
- R8: The phase code is control bits 3:1, read as {W,V,U} with U in bit 1. `hi_en` and `lo_en` use bit 0 for U, bit 1 for V and bit 2 for W. The codes map as follows:
  - code 1: U high and W low
  - code 2: V high and U low
  - code 3: V high and W low
  - code 4: W high and V low
  - code 5: U high and V low
  - code 6: W high and U low
- R9: Phase codes 0 and 7 switch all six phase outputs off.
- R10: `bus_rdata` returns the following, combinationally from `bus_addr`:
  - address 0: the control word {12'b0, code, run}
  - address 1: dead-time
  - address 2: half-period
  - address 3: the first main counter
  - address 4: the second main counter
  - address 5: the subcounter
  - addresses 6 and 7: zero

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = full 16-bit access, 0 = narrow access (rejected) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| bus_err | output | 1 | Pulse one cycle after a narrow write |
| cnt_a | output | 16 | First main counter (dead-time preloaded) |
| cnt_b | output | 16 | Second main counter (cleared on restart) |
| cnt_sub | output | 16 | Subcounter |
| main_down | output | 2 | Down direction of main counters {b, a} |
| sub_up | output | 1 | Subcounter counting up |
| hi_en | output | 3 | High-side phase enables {W,V,U} |
| lo_en | output | 3 | Low-side phase enables {W,V,U} |

## Verification
The assertions check the following on every cycle:
- the restart load values;
- that a stopped block keeps its counters frozen;
- the turn from falling to rising when the subcounter equals the half-period register;
- the error pulse and unchanged registers after a narrow write;
- that the phase outputs never enable more than one high and one low side, and never both sides of one phase.

The exact phase code table, the peak and zero turning points of both main counters, and the refusal to restart while running can only be shown by the bench scenarios. In those scenarios the bench reference model tracks every counter through several full bounce periods with different dead-time and half-period settings.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // register address map (word addresses)
  localparam int A_CTRL   = 0;
  localparam int A_DEAD   = 1;
  localparam int A_HALF   = 2;
  localparam int A_MAIN_A = 3;
  localparam int A_MAIN_B = 4;
  localparam int A_SUB    = 5;

  // control word fields
  localparam int RUN_BIT  = 0;
  localparam int CODE_LSB = 1;
  localparam int CODE_W   = 3;

  // counter slot indices inside the timebase
  localparam int N_CTR  = 3;
  localparam int CTR_A  = 0;
  localparam int CTR_B  = 1;
  localparam int CTR_S  = 2;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic              wide,
  input  logic [DW-1:0]     wdata,
  output logic              run_q,
  output logic [CODE_W-1:0] code_q,
  output logic [DW-1:0]     dead_q,
  output logic [DW-1:0]     half_q,
  output logic              start,
  output logic              err_q
);
  logic wr_ok;
  assign wr_ok = wr && wide;
  assign start = wr_ok && (addr == AW'(A_CTRL)) && wdata[RUN_BIT] && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      code_q <= '0;
      dead_q <= '1;
      half_q <= '1;
      err_q  <= 1'b0;
    end else begin
      err_q <= wr && !wide;
      if (wr_ok) begin
        if (addr == AW'(A_CTRL)) begin
          run_q  <= wdata[RUN_BIT];
          code_q <= wdata[CODE_LSB +: CODE_W];
        end
        if (addr == AW'(A_DEAD)) dead_q <= wdata;
        if (addr == AW'(A_HALF)) half_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/cpwm_bounce.sv
module cpwm_bounce #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          en,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] cnt,
  output logic          up
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (load) begin
      cnt <= load_val;
      up  <= 1'b1;
    end else if (en) begin
      if (up && cnt == hi) begin
        up  <= 1'b0;
        cnt <= cnt - ONE;
      end else if (!up && cnt == lo) begin
        up  <= 1'b1;
        cnt <= cnt + ONE;
      end else if (up) begin
        cnt <= cnt + ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/cpwm_phase_sel.sv
module cpwm_phase_sel (
  input  logic [2:0] code,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en
);
  // bit 0 = U, bit 1 = V, bit 2 = W
  always_comb begin
    hi_en = 3'b000;
    lo_en = 3'b000;
    case (code)
      3'd1: begin hi_en = 3'b001; lo_en = 3'b100; end
      3'd2: begin hi_en = 3'b010; lo_en = 3'b001; end
      3'd3: begin hi_en = 3'b010; lo_en = 3'b100; end
      3'd4: begin hi_en = 3'b100; lo_en = 3'b010; end
      3'd5: begin hi_en = 3'b001; lo_en = 3'b010; end
      3'd6: begin hi_en = 3'b100; lo_en = 3'b001; end
      default: begin hi_en = 3'b000; lo_en = 3'b000; end
    endcase
  end
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_err,
  output logic [15:0] cnt_a,
  output logic [15:0] cnt_b,
  output logic [15:0] cnt_sub,
  output logic [1:0]  main_down,
  output logic        sub_up,
  output logic [2:0]  hi_en,
  output logic [2:0]  lo_en
);
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int PAD_W = DW - CODE_W - 1;

  logic              run_q;
  logic [CODE_W-1:0] code_q;
  logic [DW-1:0]     dead_q;
  logic [DW-1:0]     half_q;
  logic              start;
  logic [DW-1:0]     peak;
  logic [DW-1:0]     cnt_v [N_CTR];
  logic              up_v  [N_CTR];

  cpwm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wide(bus_wide),
    .wdata(bus_wdata), .run_q(run_q), .code_q(code_q), .dead_q(dead_q),
    .half_q(half_q), .start(start), .err_q(bus_err)
  );

  assign peak = dead_q + half_q;

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    logic [DW-1:0] lo_b;
    logic [DW-1:0] ld_v;
    if (g == CTR_S) begin : g_lo_half
      assign lo_b = half_q;
    end else begin : g_lo_zero
      assign lo_b = '0;
    end
    if (g == CTR_A) begin : g_ld_dead
      assign ld_v = dead_q;
    end else begin : g_ld_zero
      assign ld_v = '0;
    end
    cpwm_bounce #(.DW(DW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(ld_v), .en(run_q),
      .lo(lo_b), .hi(peak), .cnt(cnt_v[g]), .up(up_v[g])
    );
  end

  assign cnt_a     = cnt_v[CTR_A];
  assign cnt_b     = cnt_v[CTR_B];
  assign cnt_sub   = cnt_v[CTR_S];
  assign main_down = {~up_v[CTR_B], ~up_v[CTR_A]};
  assign sub_up    = up_v[CTR_S];

  cpwm_phase_sel u_phase (.code(code_q), .hi_en(hi_en), .lo_en(lo_en));

  always_comb begin
    case (bus_addr)
      AW'(A_CTRL):   bus_rdata = {{PAD_W{1'b0}}, code_q, run_q};
      AW'(A_DEAD):   bus_rdata = dead_q;
      AW'(A_HALF):   bus_rdata = half_q;
      AW'(A_MAIN_A): bus_rdata = cnt_v[CTR_A];
      AW'(A_MAIN_B): bus_rdata = cnt_v[CTR_B];
      AW'(A_SUB):    bus_rdata = cnt_v[CTR_S];
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpwm_timebase_chk.sv
module cpwm_timebase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_wide,
  input logic [15:0] bus_wdata,
  input logic        bus_err,
  input logic [15:0] cnt_a,
  input logic [15:0] cnt_b,
  input logic [15:0] cnt_sub,
  input logic        sub_up,
  input logic [2:0]  hi_en,
  input logic [2:0]  lo_en,
  input logic        run,
  input logic [15:0] dead,
  input logic [15:0] half
);
  logic go_req;
  assign go_req = bus_wr && bus_wide && bus_addr == 3'd0 && bus_wdata[0] && !run;

  // R4
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> (cnt_a == $past(dead)) && (cnt_b == 16'd0) && (cnt_sub == 16'd0) && sub_up);

  // R7
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !go_req) |=> $stable(cnt_a) && $stable(cnt_b) && $stable(cnt_sub));

  // R6
  sub_turn_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !go_req && !sub_up && cnt_sub == half) |=> sub_up && (cnt_sub == $past(cnt_sub) + 16'd1));

  // R2
  narrow_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wide) |=> bus_err && $stable(dead) && $stable(half) && $stable(run));

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_wide) |=> !bus_err);

  // R8
  phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_en) && $onehot0(lo_en) && ((hi_en & lo_en) == 3'b000));
endmodule

bind cpwm_timebase cpwm_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wide(bus_wide),
  .bus_wdata(bus_wdata), .bus_err(bus_err), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .cnt_sub(cnt_sub), .sub_up(sub_up), .hi_en(hi_en), .lo_en(lo_en),
  .run(run_q), .dead(dead_q), .half(half_q)
);

// File: tb/test_cpwm_timebase.sv
`timescale 1ns/1ps
module test_cpwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] cnt_a, cnt_b, cnt_sub;
  logic [1:0]  main_down;
  logic        sub_up;
  logic [2:0]  hi_en, lo_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpwm_timebase i_cpwm_timebase (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .cnt_a(cnt_a),
    .cnt_b(cnt_b), .cnt_sub(cnt_sub), .main_down(main_down), .sub_up(sub_up),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  // ---------------- reference model ----------------
  int m_a, m_b, m_s, m_dead, m_half, m_code, m_run, m_err;
  bit u_a, u_b, u_s;

  function automatic void step(inout int v, inout bit up, input int lo, input int hi);
    if (up && v == hi) begin up = 1'b0; v = v - 1; end
    else if (!up && v == lo) begin up = 1'b1; v = v + 1; end
    else v = up ? v + 1 : v - 1;
    v = v & 16'hFFFF;
  endfunction

  function automatic logic [5:0] phase_of(input int code);
    // returns {lo[W,V,U], hi[W,V,U]}
    case (code)
      1: return {3'b100, 3'b001};
      2: return {3'b001, 3'b010};
      3: return {3'b100, 3'b010};
      4: return {3'b010, 3'b100};
      5: return {3'b010, 3'b001};
      6: return {3'b001, 3'b100};
      default: return 6'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_s = 0; m_dead = 16'hFFFF; m_half = 16'hFFFF;
      m_code = 0; m_run = 0; m_err = 0; u_a = 1; u_b = 1; u_s = 1;
    end else begin
      int pk;
      bit go;
      pk = (m_dead + m_half) & 16'hFFFF;
      go = bus_wr && bus_wide && bus_addr == 3'd0 && bus_wdata[0] && m_run == 0;
      if (go) begin
        m_a = m_dead; m_b = 0; m_s = 0; u_a = 1; u_b = 1; u_s = 1;
      end else if (m_run != 0) begin
        step(m_a, u_a, 0, pk);
        step(m_b, u_b, 0, pk);
        step(m_s, u_s, m_half, pk);
      end
      m_err = (bus_wr && !bus_wide) ? 1 : 0;
      if (bus_wr && bus_wide) begin
        if (bus_addr == 3'd0) begin m_run = bus_wdata[0]; m_code = int'(bus_wdata[3:1]); end
        if (bus_addr == 3'd1) m_dead = bus_wdata;
        if (bus_addr == 3'd2) m_half = bus_wdata;
      end
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return (m_code << 1) | m_run;
      1: return m_dead;
      2: return m_half;
      3: return m_a;
      4: return m_b;
      5: return m_s;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [5:0] ph;
      ph = phase_of(m_code);
      check("R5", "cnt_a", int'(cnt_a), m_a);
      check("R5", "cnt_b", int'(cnt_b), m_b);
      check("R5", "main_down", int'(main_down), {u_b ? 0 : 2} | (u_a ? 0 : 1));
      check("R6", "cnt_sub", int'(cnt_sub), m_s);
      check("R6", "sub_up", int'(sub_up), int'(u_s));
      check("R8", "hi_en", int'(hi_en), int'(ph[2:0]));
      check("R8", "lo_en", int'(lo_en), int'(ph[5:3]));
      check("R2", "bus_err", int'(bus_err), m_err);
      check("R10", "bus_rdata", int'(bus_rdata), model_read(int'(bus_addr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d, input bit wide);
    @(posedge clk); #2;
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_wide = wide; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_wide = 1'b1;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    #0 bus_addr = 3'(a);
    @(negedge clk);
    check(req, "read", int'(bus_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset values
    rd_chk(1, 16'hFFFF, "R1");
    rd_chk(2, 16'hFFFF, "R1");
    rd_chk(0, 0, "R1");
    rd_chk(5, 0, "R1");
    check("R1", "hi_en", int'(hi_en), 0);
    check("R1", "main_down", int'(main_down), 0);
    // R2: narrow write rejected
    wr(1, 16'h0007, 1'b0);
    @(negedge clk);
    check("R2", "err pulse", int'(bus_err), 1);
    rd_chk(1, 16'hFFFF, "R2");
    check("R2", "err cleared", int'(bus_err), 0);
    // program dead=3 half=5
    wr(1, 3, 1'b1);
    wr(2, 5, 1'b1);
    // R3: counter addresses read-only
    wr(3, 16'h1234, 1'b1);
    wr(4, 16'h1234, 1'b1);
    wr(5, 16'h1234, 1'b1);
    rd_chk(3, 0, "R3");
    rd_chk(4, 0, "R3");
    rd_chk(5, 0, "R3");
    // R4: restart with code 1
    wr(0, (1 << 1) | 1, 1'b1);
    @(negedge clk);
    check("R4", "cnt_a load", int'(cnt_a), 3);
    check("R4", "cnt_b load", int'(cnt_b), 0);
    check("R4", "cnt_sub load", int'(cnt_sub), 0);
    idle(40);
    // R7: write run again while running -> no restart
    wr(0, (4 << 1) | 1, 1'b1);
    idle(20);
    // R7: stop and hold
    wr(0, 0, 1'b1);
    @(negedge clk);
    begin
      int ha;
      ha = int'(cnt_a);
      idle(6);
      @(negedge clk);
      check("R7", "frozen", int'(cnt_a), ha);
    end
    // R8 / R9: all phase codes
    for (int c = 0; c < 8; c++) begin
      logic [5:0] p;
      wr(0, c << 1, 1'b1);
      @(negedge clk);
      p = phase_of(c);
      if (c == 0 || c == 7) check("R9", "all off", int'({lo_en, hi_en}), 0);
      else check("R8", "code map", int'({lo_en, hi_en}), int'(p));
    end
    // second profile: dead=1 half=2, restart
    wr(1, 1, 1'b1);
    wr(2, 2, 1'b1);
    wr(0, (6 << 1) | 1, 1'b1);
    @(negedge clk);
    check("R4", "cnt_a reload", int'(cnt_a), 1);
    idle(30);
    // third profile: dead=10 half=40
    wr(0, 0, 1'b1);
    wr(1, 10, 1'b1);
    wr(2, 40, 1'b1);
    wr(0, (3 << 1) | 1, 1'b1);
    idle(300);
    rd_chk(7, 0, "R10");
    finish_run();
  end
endmodule